// File: doc/BRIEF.md
# Watchdog Timer with Dual-Strobe Clear

This block is a watchdog counter for a small processor core. It counts base ticks taken either from a free-running low-power oscillator enable or from an internal divider of the system clock. Those ticks pass through a prescaler with a selectable ratio of 1 to 128 in powers of two, and then through a timeout counter. If software fails to restart the count in time, the block raises a sticky timeout flag. If the core is running, it also issues a one-cycle chip-reset request. If the core is halted, it issues a one-cycle wake-up request instead, which the core uses to restart only its program counter and stack pointer.

Two clear strobes stand for two distinct clear instructions. A configuration input chooses between two clear modes. In the first, either strobe restarts the count. In the second, both strobes must have been seen before the count restarts. A halt strobe from the core sets a power-down flag. A restart clears both the power-down flag and the timeout flag. The oscillator source keeps counting while the core is halted. The divided system-clock source freezes during halt, because the system clock is stopped.

Top module: `wdog_dualclr`

## Requirements
- R1: After the synchronous reset, `to_flag`, `pd_flag`, `rst_req` and `wake_req` are 0, and the count starts from zero.
- R2: A timeout occurs on the base tick that completes 2^CNT_W × 2^P base ticks since the last restart. P is the 3-bit value on `cfg_presc`, from 0 to 7, giving prescaler ratios 1 to 128.
- R3: A timeout sets `to_flag` on the clock edge that takes the final tick. The flag stays set until a restart.
- R4: A timeout with `core_halted` = 0 drives `rst_req` high for exactly one cycle, starting at the edge that takes the final tick. `wake_req` stays 0.
- R5: A timeout with `core_halted` = 1 drives `wake_req` high for exactly one cycle. `rst_req` stays 0.
- R6: A cycle with `halt_strb` = 1 sets `pd_flag`. A restart clears `pd_flag` and `to_flag`. If `halt_strb` and a restart fall in the same cycle, `pd_flag` is set.
- R7: With `cfg_dual_clr` = 0, a single cycle of either `clr_a` or `clr_b` restarts the count: the prescaler and the counter both go to zero.
- R8: With `cfg_dual_clr` = 1, the count restarts only once both strobes have been seen, in either order or in the same cycle. A repeated strobe of one kind counts once. The record of seen strobes empties at every restart.
- R9: With `cfg_enable` = 0, the prescaler and the counter are held at zero, no timeout occurs, and neither request is raised.
- R10: With `cfg_src_sel` = 0, every clock cycle with `osc_tick` = 1 is one base tick, whether or not the core is halted. With `cfg_src_sel` = 1, one base tick occurs every SYS_DIV clock cycles, and these ticks are frozen while `core_halted` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | 1 enables counting |
| cfg_src_sel | input | 1 | Tick source: 0 = oscillator enable, 1 = divided system clock |
| cfg_presc | input | 3 | Prescaler ratio exponent P (ratio 2^P) |
| cfg_dual_clr | input | 1 | 1 requires both clear strobes before a restart |
| osc_tick | input | 1 | One-cycle tick from the watchdog oscillator |
| clr_a | input | 1 | First clear strobe |
| clr_b | input | 1 | Second clear strobe |
| halt_strb | input | 1 | Core has executed a halt |
| core_halted | input | 1 | Level: the core is in halt |
| to_flag | output | 1 | Sticky timeout flag |
| pd_flag | output | 1 | Sticky power-down flag |
| rst_req | output | 1 | One-cycle chip-reset request |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
On every cycle, the embedded properties check the following:
- each request lasts one cycle, and the two requests are never raised together;
- a chip-reset request always comes with a set timeout flag;
- a wake-up request is only raised after a halted cycle;
- the power-down flag only rises after a halt strobe;
- a disabled watchdog raises no request.

The exact timeout period for each prescaler setting can only be shown by the bench's scenarios. The same holds for:
- the ordering rules of the dual-strobe clear, including repeated strobes;
- flag clearing on restart;
- the freezing of the system-clock source during halt.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Largest prescaler exponent; ratio runs 2^0 .. 2^PRESC_MAX_LOG
    localparam int PRESC_MAX_LOG = 7;
    localparam int PRESC_SEL_W   = 3;

    typedef enum logic {
        SRC_OSC = 1'b0,
        SRC_SYS = 1'b1
    } wd_src_e;

    typedef struct packed {
        logic timeout;
        logic powerdown;
    } wd_flags_t;

    // Low-bit mask whose all-ones state marks the last tick of a prescaler period
    function automatic logic [PRESC_MAX_LOG-1:0] presc_mask(input logic [PRESC_SEL_W-1:0] sel);
        logic [PRESC_MAX_LOG:0] m;
        m = ((PRESC_MAX_LOG+1)'(1) << sel) - (PRESC_MAX_LOG+1)'(1);
        return m[PRESC_MAX_LOG-1:0];
    endfunction

endpackage

// File: rtl/wdog_tick_src.sv
module wdog_tick_src #(
    parameter int SYS_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic src_sel,
    input  logic osc_tick,
    input  logic core_halted,
    output logic base_tick
);
    import wdog_pkg::*;

    logic sys_tick;

    generate
        if (SYS_DIV <= 1) begin : g_nodiv
            // system clock used directly, stopped in halt
            assign sys_tick = !core_halted;
        end else begin : g_div
            localparam int DIV_W = $clog2(SYS_DIV);
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SYS_DIV - 1);
            logic [DIV_W-1:0] div_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    div_q <= '0;
                end else if (!core_halted) begin
                    div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
                end
            end

            assign sys_tick = !core_halted && (div_q == DIV_LAST);
        end
    endgenerate

    assign base_tick = (wd_src_e'(src_sel) == SRC_SYS) ? sys_tick : osc_tick;

endmodule

// File: rtl/wdog_clr_qual.sv
module wdog_clr_qual (
    input  logic clk,
    input  logic rst,
    input  logic dual_mode,
    input  logic clr_a,
    input  logic clr_b,
    output logic restart
);
    localparam int NUM_CLR = 2;

    logic [NUM_CLR-1:0] strobe;
    logic [NUM_CLR-1:0] seen_q;
    logic [NUM_CLR-1:0] have;

    assign strobe = {clr_b, clr_a};

    // dual mode needs every strobe recorded or present; single mode needs any
    assign restart = dual_mode ? (&have) : (|strobe);

    generate
        for (genvar i = 0; i < NUM_CLR; i++) begin : g_seen
            assign have[i] = seen_q[i] | strobe[i];

            always_ff @(posedge clk) begin
                if (rst || restart || !dual_mode) begin
                    seen_q[i] <= 1'b0;
                end else if (strobe[i]) begin
                    seen_q[i] <= 1'b1;
                end
            end
        end
    endgenerate

    // R8: dual mode never restarts unless both kinds are accounted for
    a_r8_dual_needs_both: assert property (@(posedge clk) disable iff (rst)
        (dual_mode && restart) |-> (have == {NUM_CLR{1'b1}}));

    // R7: single mode restarts on any strobe
    a_r7_single_any: assert property (@(posedge clk) disable iff (rst)
        (!dual_mode && (clr_a || clr_b)) |-> restart);

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              enable,
    input  logic                              restart,
    input  logic                              base_tick,
    input  logic [wdog_pkg::PRESC_SEL_W-1:0]  presc_sel,
    output logic                              timeout
);
    import wdog_pkg::*;

    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    logic [PRESC_MAX_LOG-1:0] pre_q;
    logic [CNT_W-1:0]         cnt_q;
    logic [PRESC_MAX_LOG-1:0] mask;
    logic                     pre_done;

    assign mask     = presc_mask(presc_sel);
    assign pre_done = base_tick && ((pre_q & mask) == mask);
    assign timeout  = enable && !restart && pre_done && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || !enable) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (base_tick) begin
            pre_q <= pre_q + 1'b1;
            if (pre_done) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R9: a disabled counter sits at zero
    a_r9_held_zero: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (cnt_q == '0) && (pre_q == '0));

endmodule

// File: rtl/wdog_dualclr.sv
module wdog_dualclr #(
    parameter int CNT_W   = 8,
    parameter int SYS_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_enable,
    input  logic       cfg_src_sel,
    input  logic [2:0] cfg_presc,
    input  logic       cfg_dual_clr,
    input  logic       osc_tick,
    input  logic       clr_a,
    input  logic       clr_b,
    input  logic       halt_strb,
    input  logic       core_halted,
    output logic       to_flag,
    output logic       pd_flag,
    output logic       rst_req,
    output logic       wake_req
);
    import wdog_pkg::*;

    logic      base_tick;
    logic      restart;
    logic      timeout;
    wd_flags_t flags_q;
    logic      rst_req_q;
    logic      wake_req_q;

    wdog_tick_src #(.SYS_DIV(SYS_DIV)) i_src (
        .clk         (clk),
        .rst         (rst),
        .src_sel     (cfg_src_sel),
        .osc_tick    (osc_tick),
        .core_halted (core_halted),
        .base_tick   (base_tick)
    );

    wdog_clr_qual i_clr (
        .clk       (clk),
        .rst       (rst),
        .dual_mode (cfg_dual_clr),
        .clr_a     (clr_a),
        .clr_b     (clr_b),
        .restart   (restart)
    );

    wdog_count #(.CNT_W(CNT_W)) i_cnt (
        .clk       (clk),
        .rst       (rst),
        .enable    (cfg_enable),
        .restart   (restart),
        .base_tick (base_tick),
        .presc_sel (cfg_presc),
        .timeout   (timeout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q    <= '0;
            rst_req_q  <= 1'b0;
            wake_req_q <= 1'b0;
        end else begin
            rst_req_q  <= timeout && !core_halted;
            wake_req_q <= timeout && core_halted;
            if (restart) begin
                flags_q.timeout <= 1'b0;
            end else if (timeout) begin
                flags_q.timeout <= 1'b1;
            end
            if (halt_strb) begin
                flags_q.powerdown <= 1'b1;
            end else if (restart) begin
                flags_q.powerdown <= 1'b0;
            end
        end
    end

    assign to_flag  = flags_q.timeout;
    assign pd_flag  = flags_q.powerdown;
    assign rst_req  = rst_req_q;
    assign wake_req = wake_req_q;

    a_r4_rst_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    a_r5_wake_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> !wake_req);

    a_r5_req_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && wake_req));

    a_r3_req_has_flag: assert property (@(posedge clk) disable iff (rst)
        (rst_req || wake_req) |-> to_flag);

    a_r5_wake_after_halt: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> $past(core_halted));

    a_r6_pd_from_halt: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_flag) |-> $past(halt_strb));

    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> !rst_req && !wake_req);

endmodule

// File: tb/test_wdog_dualclr.sv
module test_wdog_dualclr;

    localparam int CNT_W   = 4;
    localparam int SYS_DIV = 2;
    localparam int BASE    = 1 << CNT_W;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_enable = 1'b1;
    logic       cfg_src_sel = 1'b0;
    logic [2:0] cfg_presc = 3'd0;
    logic       cfg_dual_clr = 1'b0;
    logic       osc_tick = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       halt_strb = 1'b0;
    logic       core_halted = 1'b0;
    logic       to_flag, pd_flag, rst_req, wake_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5ns clk = ~clk;

    wdog_dualclr #(.CNT_W(CNT_W), .SYS_DIV(SYS_DIV)) i_wdog_dualclr (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_src_sel(cfg_src_sel),
        .cfg_presc(cfg_presc), .cfg_dual_clr(cfg_dual_clr), .osc_tick(osc_tick),
        .clr_a(clr_a), .clr_b(clr_b), .halt_strb(halt_strb), .core_halted(core_halted),
        .to_flag(to_flag), .pd_flag(pd_flag), .rst_req(rst_req), .wake_req(wake_req)
    );

    // vector: {prescaler exponent, tick count after restart, expected to_flag}
    localparam int VEC_N = 8;
    localparam logic [19:0] VEC [VEC_N] = '{
        {3'd0, 16'd15,   1'b0},
        {3'd0, 16'd16,   1'b1},
        {3'd1, 16'd31,   1'b0},
        {3'd1, 16'd32,   1'b1},
        {3'd3, 16'd127,  1'b0},
        {3'd3, 16'd128,  1'b1},
        {3'd7, 16'd2047, 1'b0},
        {3'd7, 16'd2048, 1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) osc_tick = 1'b1;
            @(negedge clk) osc_tick = 1'b0;
        end
    endtask

    task automatic pulse_a();
        @(negedge clk) clr_a = 1'b1;
        @(negedge clk) clr_a = 1'b0;
    endtask

    task automatic pulse_b();
        @(negedge clk) clr_b = 1'b1;
        @(negedge clk) clr_b = 1'b0;
    endtask

    task automatic pulse_ab();
        @(negedge clk) begin clr_a = 1'b1; clr_b = 1'b1; end
        @(negedge clk) begin clr_a = 1'b0; clr_b = 1'b0; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!to_flag && !pd_flag, "R1 flags", {to_flag, pd_flag}, 0);
        check(!rst_req && !wake_req, "R1 requests", {rst_req, wake_req}, 0);

        // R2 R3 R7 vector table: clr_a restarts, then count ticks
        for (int v = 0; v < VEC_N; v++) begin
            cfg_presc = VEC[v][19:17];
            pulse_a();
            ticks(int'(VEC[v][16:1]));
            check(to_flag == VEC[v][0], "R2 period", to_flag, VEC[v][0]);
        end

        // R4 reset request is a single cycle
        cfg_presc = 3'd0;
        pulse_a();
        ticks(BASE - 1);
        check(!rst_req, "R4 before", rst_req, 0);
        ticks(1);
        check(rst_req && !wake_req, "R4 pulse", {rst_req, wake_req}, 2);
        @(negedge clk);
        check(!rst_req, "R4 one cycle", rst_req, 0);
        check(to_flag, "R3 sticky", to_flag, 1);

        // R6 halt strobe then R5 wake-up in halt
        pulse_b();
        check(!to_flag, "R6 clear to", to_flag, 0);
        @(negedge clk) halt_strb = 1'b1;
        @(negedge clk) halt_strb = 1'b0;
        check(pd_flag, "R6 pd set", pd_flag, 1);
        core_halted = 1'b1;
        ticks(BASE);
        check(wake_req && !rst_req, "R5 wake", {wake_req, rst_req}, 2);
        @(negedge clk);
        check(!wake_req, "R5 one cycle", wake_req, 0);
        check(to_flag && pd_flag, "R3 R6 flags", {to_flag, pd_flag}, 3);
        core_halted = 1'b0;
        pulse_a();
        check(!to_flag && !pd_flag, "R6 restart clears", {to_flag, pd_flag}, 0);

        // R6 halt wins over a restart in the same cycle
        @(negedge clk) begin halt_strb = 1'b1; clr_a = 1'b1; end
        @(negedge clk) begin halt_strb = 1'b0; clr_a = 1'b0; end
        check(pd_flag, "R6 halt priority", pd_flag, 1);

        // R8 dual mode: repeated strobe counts once, order a then b
        cfg_dual_clr = 1'b1;
        pulse_ab();
        ticks(10);
        pulse_a();
        pulse_a();
        ticks(BASE - 10);
        check(to_flag, "R8 repeat no restart", to_flag, 1);
        pulse_b();
        check(!to_flag, "R8 a then b restarts", to_flag, 0);
        ticks(BASE - 1);
        check(!to_flag, "R8 count restarted", to_flag, 0);
        ticks(1);
        check(to_flag, "R8 period after restart", to_flag, 1);
        // order b then a, record emptied at last restart
        pulse_b();
        check(to_flag, "R8 b alone", to_flag, 1);
        pulse_a();
        check(!to_flag, "R8 b then a restarts", to_flag, 0);
        ticks(5);
        pulse_a();
        check(!to_flag, "R8 record empty", to_flag, 0);
        ticks(BASE - 5);
        check(to_flag, "R8 single a ignored", to_flag, 1);
        pulse_ab();
        check(!to_flag, "R8 same cycle", to_flag, 0);
        cfg_dual_clr = 1'b0;

        // R7 clr_b alone in single mode
        ticks(BASE - 2);
        pulse_b();
        ticks(BASE - 1);
        check(!to_flag, "R7 clr_b restarts", to_flag, 0);

        // R9 disabled
        cfg_enable = 1'b0;
        ticks(3 * BASE);
        check(!to_flag && !rst_req, "R9 disabled", {to_flag, rst_req}, 0);
        cfg_enable = 1'b1;
        ticks(BASE - 1);
        check(!to_flag, "R9 counter held at zero", to_flag, 0);
        ticks(1);
        check(to_flag, "R9 resumes", to_flag, 1);

        // R10 system-clock source frozen in halt
        cfg_src_sel = 1'b1;
        core_halted = 1'b1;
        pulse_a();
        repeat (100) @(negedge clk);
        check(!to_flag, "R10 frozen in halt", to_flag, 0);
        core_halted = 1'b0;
        repeat (BASE * SYS_DIV - 4) @(negedge clk);
        check(!to_flag, "R10 not yet", to_flag, 0);
        repeat (8) @(negedge clk);
        check(to_flag, "R10 divided source", to_flag, 1);
        // oscillator source keeps counting in halt
        cfg_src_sel = 1'b0;
        pulse_a();
        core_halted = 1'b1;
        ticks(BASE);
        check(to_flag && wake_req, "R10 osc in halt", {to_flag, wake_req}, 3);
        core_halted = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule